// File: doc/BRIEF.md
# Time-Multiplexed Multi-Voice DDS Engine

This block is a direct digital synthesis core that serves several voices with a single adder and a single waveshape RAM. A slot strobe advances a channel sequencer; on each slot the engine fetches that channel's frequency increment and its 32-bit phase. It adds the two, stores the result back, and uses the top phase bits, prefixed by the channel number, to look up an 8-bit sample in the shared waveshape RAM. Every slot produces one sample, tagged with its channel number and marked by a valid strobe.

A mode input trades voices against table length. The 1024-entry RAM is split into 4 tables of 256 entries, 8 tables of 128 or 16 tables of 64. With a 10 MHz per-voice update rate, the slot strobe runs at 10 MHz times the voice count. The output frequency is increment × 10 MHz / 2^32, so an increment of 188979 gives about 440.001 Hz. A host write port loads increments and table contents while the engine runs. A per-channel clear input forces a phase back to zero.

Top module: `tdm_dds_engine`

## Requirements
- R1: After reset every stored phase and every increment is zero, `smp_valid` is low and `smp_chan`/`smp_data` are zero. The first slots therefore output table entry {channel, 0}.
- R2: Each slot strobe serves one channel, in ascending order with wrap-around. `mode` 0 selects 4 channels, 1 selects 8, and 2 or 3 select 16.
- R3: On each slot of channel c, the stored phase of c becomes its old phase plus its increment, modulo 2^32.
- R4: The sample of a slot is waveshape entry {c, phase[31 -: k]}, taken from the updated phase. k is 8, 7 or 6 in modes 0, 1 and 2/3, and c fills the remaining upper bits of the 10-bit table index.
- R5: A slot strobe sampled high at clock edge N makes `smp_valid` high for one cycle after edge N+3, with `smp_chan` equal to the served channel.
- R6: If `phase_clr[c]` is high at the edge one cycle after channel c's slot strobe, that slot stores phase zero and outputs entry {c, 0}.
- R7: Rewriting a channel's increment leaves its stored phase untouched. Later slots continue from the current phase with the new step.
- R8: A host write with `host_sel`=0 sets the increment of channel `host_addr[3:0]` to `host_wdata`. With `host_sel`=1 it sets waveshape entry `host_addr` to `host_wdata[7:0]`.
- R9: A host write at the same edge at which a slot reads that increment or that waveshape entry gives the slot the old value. The new value applies from the next read.
- R10: While `smp_valid` is low, `smp_chan` and `smp_data` keep their last values. Cycles without a slot strobe advance nothing.
- R11: If the sequencer position is at or beyond the channel count of a newly selected mode, the next slot serves channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Voice count select: 0=4, 1=8, 2/3=16 |
| slot_en | input | 1 | Slot strobe; launches one channel per high cycle |
| phase_clr | input | 16 | Per-channel phase clear request |
| host_we | input | 1 | Host write enable |
| host_sel | input | 1 | Host write target: 0 increment, 1 waveshape |
| host_addr | input | 10 | Channel (low 4 bits) or waveshape index |
| host_wdata | input | 32 | Increment value, or sample in the low 8 bits |
| smp_valid | output | 1 | One-cycle strobe per finished slot |
| smp_chan | output | 4 | Channel of the current sample |
| smp_data | output | 8 | Sample value |

## Verification
Host writes can collide with slot processing in the same cycle. An increment write can land at the edge where a slot fetches that channel's increment. A waveshape write can land at the edge where the table read of a running slot uses the same entry. The bench provokes this in two ways. It holds one channel at a zero increment so that its table index never moves, then rewrites that entry on every cycle. It also rewrites the increments of the 4-channel rotation on every cycle. A cycle-accurate model applies reads before writes at each edge, and every output cycle is compared against it, so the old-value rule shows up in the samples.

// File: rtl/tdm_dds_engine.sv
module tdm_dds_engine #(
  parameter int PH_W    = 32,
  parameter int SMP_W   = 8,
  parameter int CH_W    = 4,
  parameter int IDX_MIN = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic                      slot_en,
  input  logic [(1<<CH_W)-1:0]      phase_clr,
  input  logic                      host_we,
  input  logic                      host_sel,
  input  logic [CH_W+IDX_MIN-1:0]   host_addr,
  input  logic [PH_W-1:0]           host_wdata,
  output logic                      smp_valid,
  output logic [CH_W-1:0]           smp_chan,
  output logic [SMP_W-1:0]          smp_data
);
  localparam int NCH    = 1 << CH_W;
  localparam int TBL_AW = CH_W + IDX_MIN;
  localparam int TBL_N  = 1 << TBL_AW;

  logic [PH_W-1:0]   addend_q [NCH];
  logic [PH_W-1:0]   phase_q  [NCH];
  logic [SMP_W-1:0]  wave     [TBL_N];

  logic [CH_W:0]     nch;
  logic [CH_W-1:0]   ctr, cur, nxt;

  logic              s1_v, s2_v, s3_v;
  logic [CH_W-1:0]   s1_ch, s2_ch, s3_ch;
  logic [PH_W-1:0]   s1_add, s1_ph, nph;
  logic [TBL_AW-1:0] s2_addr, wa_nx;
  logic [SMP_W-1:0]  s3_d;

  always_comb begin
    case (mode)
      2'd0:    nch = (CH_W+1)'(NCH / 4);
      2'd1:    nch = (CH_W+1)'(NCH / 2);
      default: nch = (CH_W+1)'(NCH);
    endcase
  end

  assign cur = ({1'b0, ctr} < nch) ? ctr : '0;
  assign nxt = (({1'b0, cur} + 1'b1) == nch) ? '0 : cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctr <= '0;
    else if (slot_en) ctr <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) addend_q[i] <= '0;
    end else if (host_we && !host_sel) begin
      addend_q[host_addr[CH_W-1:0]] <= host_wdata;
    end

  always_ff @(posedge clk)
    if (host_we && host_sel) wave[host_addr] <= host_wdata[SMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      s1_v <= slot_en;
      s2_v <= s1_v;
      s3_v <= s2_v;
      smp_valid <= s3_v;
    end

  always_ff @(posedge clk)
    if (slot_en) begin
      s1_ch  <= cur;
      s1_add <= addend_q[cur];
      s1_ph  <= phase_q[cur];
    end

  assign nph = phase_clr[s1_ch] ? '0 : s1_ph + s1_add;

  always_comb begin
    case (mode)
      2'd0:    wa_nx = {s1_ch[CH_W-3:0], nph[PH_W-1 -: IDX_MIN+2]};
      2'd1:    wa_nx = {s1_ch[CH_W-2:0], nph[PH_W-1 -: IDX_MIN+1]};
      default: wa_nx = {s1_ch,           nph[PH_W-1 -: IDX_MIN]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) phase_q[i] <= '0;
    end else if (s1_v) begin
      phase_q[s1_ch] <= nph;
    end

  always_ff @(posedge clk) begin
    s2_ch   <= s1_ch;
    s2_addr <= wa_nx;
    s3_ch   <= s2_ch;
    s3_d    <= wave[s2_addr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp_chan <= '0;
      smp_data <= '0;
    end else if (s3_v) begin
      smp_chan <= s3_ch;
      smp_data <= s3_d;
    end
endmodule

// File: rtl/tdm_dds_engine_chk.sv
module tdm_dds_engine_chk #(
  parameter int SMP_W = 8,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             slot_en,
  input logic             smp_valid,
  input logic [CH_W-1:0]  smp_chan,
  input logic [SMP_W-1:0] smp_data
);
  logic [2:0]    age;
  logic [2:0]    mode_age;
  logic [1:0]    mode_q;
  logic [CH_W:0] lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age      <= '0;
      mode_age <= '0;
      mode_q   <= '0;
    end else begin
      if (age != 3'd4) age <= age + 1'b1;
      mode_q <= mode;
      if (mode != mode_q)          mode_age <= '0;
      else if (mode_age != 3'd4)   mode_age <= mode_age + 1'b1;
    end

  assign lim = (mode == 2'd0) ? (CH_W+1)'((1 << CH_W) / 4) :
               (mode == 2'd1) ? (CH_W+1)'((1 << CH_W) / 2) : (CH_W+1)'(1 << CH_W);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 3'd4) |-> !smp_valid);

  p_slot_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (smp_valid == $past(slot_en, 4)));

  p_chan_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_age == 3'd4 && mode == mode_q) |-> ({1'b0, smp_chan} < lim));

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 3'd0 && !smp_valid) |-> ($stable(smp_chan) && $stable(smp_data)));
endmodule

bind tdm_dds_engine tdm_dds_engine_chk #(.SMP_W(SMP_W), .CH_W(CH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .slot_en(slot_en),
  .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
);

// File: tb/test_tdm_dds_engine.sv
module test_tdm_dds_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        slot_en = 1'b0;
  logic [15:0] phase_clr = '0;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        smp_valid;
  logic [3:0]  smp_chan;
  logic [7:0]  smp_data;

  always #5 clk = ~clk;

  tdm_dds_engine i_tdm_dds_engine (
    .clk(clk), .rst_n(rst_n), .mode(mode), .slot_en(slot_en), .phase_clr(phase_clr),
    .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data));

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference
  bit [31:0] m_add [16];
  bit [31:0] m_ph  [16];
  bit [7:0]  m_wave [1024];
  int        m_ctr;
  bit        q1_v, q2_v, q3_v, e_v;
  int        q1_ch, q2_ch, q3_ch, e_ch;
  bit [31:0] q1_add;
  int        q2_addr;
  bit [7:0]  q3_d, e_d;

  function automatic int chans(input logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 8 : 16;
  endfunction

  function automatic int tbl_index(input logic [1:0] m, input int ch, input bit [31:0] ph);
    int k;
    k = (m == 2'd0) ? 8 : (m == 2'd1) ? 7 : 6;
    return ch * (1 << k) + int'(ph >> (32 - k));
  endfunction

  function automatic bit [7:0] shape(input int i);
    return 8'(((i * 37) ^ ((i >> 5) * 91)) + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_add[i] = 0; m_ph[i] = 0; end
      m_ctr = 0; q1_v = 0; q2_v = 0; q3_v = 0; e_v = 0; e_ch = 0; e_d = 0;
    end else begin
      e_v = q3_v;
      if (q3_v) begin e_ch = q3_ch; e_d = q3_d; end
      q3_v = q2_v; q3_ch = q2_ch; q3_d = m_wave[q2_addr];
      q2_v = q1_v;
      if (q1_v) begin
        bit [31:0] p;
        p = phase_clr[q1_ch] ? 32'd0 : m_ph[q1_ch] + q1_add;
        m_ph[q1_ch] = p;
        q2_ch = q1_ch;
        q2_addr = tbl_index(mode, q1_ch, p);
      end
      q1_v = slot_en;
      if (slot_en) begin
        int c;
        c = (m_ctr < chans(mode)) ? m_ctr : 0;
        q1_ch = c; q1_add = m_add[c];
        m_ctr = (c + 1) % chans(mode);
      end
      if (host_we) begin
        if (host_sel) m_wave[host_addr] = host_wdata[7:0];
        else          m_add[host_addr[3:0]] = host_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (smp_valid !== e_v || (e_v && (smp_chan !== 4'(e_ch) || smp_data !== e_d)) ||
          (!e_v && (smp_chan !== 4'(e_ch) || smp_data !== e_d))) begin
        errors++;
        $display("FAIL %s: got v=%0b ch=%0d d=%0h, expected v=%0b ch=%0d d=%0h",
                 tag, smp_valid, smp_chan, smp_data, e_v, e_ch, e_d);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_wr(input bit sel, input int addr, input bit [31:0] d);
    tick();
    host_we = 1'b1; host_sel = sel; host_addr = 10'(addr); host_wdata = d;
    tick();
    host_we = 1'b0;
  endtask

  task automatic run(input int n);
    tick(); slot_en = 1'b1;
    repeat (n) tick();
    slot_en = 1'b0;
    repeat (5) tick();
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    checks++;
    if (smp_valid !== 1'b0 || smp_chan !== 4'd0 || smp_data !== 8'd0) begin
      errors++;
      $display("FAIL R1: reset outputs v=%0b ch=%0d d=%0h, expected 0 0 0",
               smp_valid, smp_chan, smp_data);
    end

    tag = "R8";
    tick();
    for (int i = 0; i < 1024; i++) begin
      host_we = 1'b1; host_sel = 1'b1; host_addr = 10'(i); host_wdata = 32'(shape(i));
      tick();
    end
    host_we = 1'b0;

    tag = "R1"; mode = 2'd2; run(40);

    tag = "R8";
    host_wr(0, 0, 32'd188979);
    host_wr(0, 1, 32'd11811);
    host_wr(0, 2, 32'd1797877);
    host_wr(0, 3, 32'hFFFF_FF00);
    host_wr(0, 4, 32'h8000_0000);
    host_wr(0, 5, 32'h0400_0000);
    for (int c = 6; c < 16; c++) host_wr(0, c, 32'h0123_4567 * c);
    tag = "R3"; run(400);

    tag = "R4"; mode = 2'd0; run(200);
    tag = "R4"; mode = 2'd1; run(200);
    tag = "R2"; mode = 2'd3; run(100);

    tag = "R11"; mode = 2'd2; run(11);
    tick(); mode = 2'd0; run(20);
    mode = 2'd2; tick(); slot_en = 1'b1;
    repeat (13) tick();
    mode = 2'd1;
    repeat (20) tick();
    slot_en = 1'b0; repeat (5) tick();

    tag = "R10"; mode = 2'd2;
    for (int k = 0; k < 300; k++) begin
      tick(); slot_en = (k % 3 == 0) || (k % 7 == 1);
    end
    slot_en = 1'b0; repeat (5) tick();

    tag = "R5"; tick(); slot_en = 1'b1; tick(); slot_en = 1'b0; repeat (8) tick();

    tag = "R6"; tick(); phase_clr = 16'h0024; run(50);
    phase_clr = 16'h8001;
    tick(); slot_en = 1'b1;
    repeat (7) tick();
    phase_clr = '0;
    repeat (40) tick();
    slot_en = 1'b0; repeat (5) tick();

    tag = "R7"; tick(); slot_en = 1'b1;
    for (int k = 0; k < 160; k++) begin
      tick();
      host_we = (k % 5 == 0); host_sel = 1'b0; host_addr = 10'(k % 16);
      host_wdata = 32'h0002_0000 * (k + 1);
    end
    host_we = 1'b0; slot_en = 1'b0; repeat (5) tick();

    tag = "R9";
    host_wr(0, 0, 32'd0);
    tick(); slot_en = 1'b1;
    for (int k = 0; k < 200; k++) begin
      tick();
      host_we = 1'b1; host_sel = 1'b1; host_addr = 10'd0; host_wdata = 32'(k * 13 + 5);
    end
    host_we = 1'b0;
    mode = 2'd0;
    for (int k = 0; k < 200; k++) begin
      tick();
      host_we = 1'b1; host_sel = 1'b0; host_addr = 10'(k % 4);
      host_wdata = 32'h0100_0000 + 32'(k) * 32'h0003_1000;
    end
    host_we = 1'b0; slot_en = 1'b0; repeat (6) tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule